// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller

This block connects a simple single-request master to an asynchronous DRAM whose row and column addresses share one set of address pins. The master presents a 21-bit byte-group address together with a read or write flag and, for writes, a data byte. The controller captures the request and splits the address into a 12-bit row (the upper bits) and a 9-bit column (the lower bits, one of 512 groups in the row). It places the row on the shared pins, strobes it in with an active-low row strobe, then switches to the column and strobes that in with an active-low column strobe.

Every strobe edge comes from the controller's own timing state machine. The master never drives a strobe. Four phase lengths are parameters counted in clock cycles: row setup, row-to-column delay, column-strobe width and precharge. At the end of the column strobe the controller captures read data and gives the master a one-cycle completion pulse. It accepts no new request until the precharge that follows the row strobe's release has run out.

Top module: `dram_mux_ctrl`

## Requirements
- R1: While reset is held and right after it, both strobes and the write-enable are high, `reqReady` is 1 and `respDone` is 0.
- R2: At the falling edge of `dramRasN`, `dramAddr` carries address bits [20:9] (the row). At the falling edge of `dramCasN`, it carries bits [8:0] (the column). The address is stable through each edge and through the whole column-strobe pulse.
- R3: `dramCasN` is low only while `dramRasN` is low. The column strobe falls only after the row strobe has been low for at least one earlier cycle.
- R4: For each access, `dramRasN` stays low for exactly T_RCD + 1 + T_CASW cycles, and `dramCasN` stays low for exactly T_CASW cycles.
- R5: `respDone` is high for exactly one cycle: the first cycle after the last column-strobe-low cycle. Counted from the cycle a request is driven with `reqReady` high, it rises T_ROWSETUP + T_RCD + T_CASW + 2 cycles later.
- R6: On a read, `respRdata` holds, in the `respDone` cycle, the byte the DRAM drove while the column strobe was low. A read returns the byte most recently written to the same 21-bit address.
- R7: On a write, `dramWeN` is low when `dramCasN` falls and `dramWdata` carries the request byte. On a read, `dramWeN` stays high. `dramWeN` does not change while `dramCasN` is low.
- R8: `reqReady` is low from the accepting edge until T_PRE cycles after `respDone` rises. Both strobes are high whenever `reqReady` is high.
- R9: A request that is presented while `reqReady` is low is dropped. It causes no DRAM access, and it does not change the address or data of the access already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; taken on a rising edge while `reqReady` is 1 |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 21 | Byte-group address: [20:9] row, [8:0] column |
| reqWdata | input | 8 | Write byte |
| reqReady | output | 1 | Controller idle and able to accept a request |
| respDone | output | 1 | One-cycle completion pulse |
| respRdata | output | 8 | Read byte, valid while `respDone` is 1 |
| dramAddr | output | 12 | Shared row/column address pins (column zero-extended) |
| dramRasN | output | 1 | Active-low row strobe |
| dramCasN | output | 1 | Active-low column strobe |
| dramWeN | output | 1 | Active-low write enable |
| dramWdata | output | 8 | Data to the DRAM |
| dramRdata | input | 8 | Data from the DRAM |

## Verification
The bench sweeps rows and columns at the edges of their ranges: all zeros, all ones, one, and alternating patterns. A controller that swapped the fields, dropped a bit or changed the bus at a strobe edge would store data at the wrong cell of the DRAM model, and the latched row or column would be off. Every access measures the strobe widths, the completion latency and the gap before ready returns. An off-by-one in any phase counter therefore shows up as a wrong cycle count. The bench also fires foreign write requests while an access is in flight. A design that took them would corrupt an unused cell or the access in progress.

// File: rtl/dram_mux_ctrl_pkg.sv
package dram_mux_ctrl_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadReq;   // capture request address and data
    logic selCol;    // drive column field on shared pins
    logic capture;   // latch read data from the DRAM
  } dpCtrl_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ROWSET,
    PH_RCD,
    PH_COLSET,
    PH_CASP,
    PH_PRE
  } phase_e;

endpackage

// File: rtl/dram_mux_ctrl_fsm.sv
module dram_mux_ctrl_fsm
  import dram_mux_ctrl_pkg::*;
#(
  parameter int T_ROWSETUP = 2,
  parameter int T_RCD      = 2,
  parameter int T_CASW     = 2,
  parameter int T_PRE      = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output dpCtrl_t ctrl,
  output logic    reqReady,
  output logic    respDone,
  output logic    rasN,
  output logic    casN,
  output logic    weN
);

  localparam int MAX_A = (T_ROWSETUP > T_RCD) ? T_ROWSETUP : T_RCD;
  localparam int MAX_B = (T_CASW > T_PRE) ? T_CASW : T_PRE;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             isWrite;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      isWrite  <= 1'b0;
      respDone <= 1'b0;
    end else begin
      respDone <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (reqValid) begin
            phase   <= PH_ROWSET;
            cnt     <= CNT_W'(T_ROWSETUP - 1);
            isWrite <= reqWrite;
          end
        end
        PH_ROWSET: begin
          if (cntZero) begin
            phase <= PH_RCD;
            cnt   <= CNT_W'(T_RCD - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_RCD: begin
          if (cntZero) phase <= PH_COLSET;
          else cnt <= cnt - 1'b1;
        end
        PH_COLSET: begin
          phase <= PH_CASP;
          cnt   <= CNT_W'(T_CASW - 1);
        end
        PH_CASP: begin
          if (cntZero) begin
            phase    <= PH_PRE;
            cnt      <= CNT_W'(T_PRE - 1);
            respDone <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        PH_PRE: begin
          if (cntZero) phase <= PH_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  logic rowActive;
  logic colPhase;

  always_comb begin
    rowActive    = (phase == PH_RCD) || (phase == PH_COLSET) || (phase == PH_CASP);
    colPhase     = (phase == PH_COLSET) || (phase == PH_CASP);
    reqReady     = (phase == PH_IDLE);
    rasN         = !rowActive;
    casN         = (phase != PH_CASP);
    weN          = !(isWrite && colPhase);
    ctrl.loadReq = (phase == PH_IDLE) && reqValid;
    ctrl.selCol  = colPhase;
    ctrl.capture = (phase == PH_CASP) && cntZero && !isWrite;
  end

endmodule

// File: rtl/dram_mux_ctrl_dp.sv
module dram_mux_ctrl_dp
  import dram_mux_ctrl_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 9,
  parameter int DATA_W = 8,
  parameter int MUX_W  = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  ctrl,
  input  logic [ROW_W+COL_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        dramRdata,
  output logic [MUX_W-1:0]         dramAddr,
  output logic [DATA_W-1:0]        dramWdata,
  output logic [DATA_W-1:0]        respRdata
);

  localparam int ADDR_W = ROW_W + COL_W;

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic [MUX_W-1:0]  rowBus;
  logic [MUX_W-1:0]  colBus;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
    end else begin
      if (ctrl.loadReq) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (ctrl.capture) rdataReg <= dramRdata;
    end
  end

  assign rowBus    = MUX_W'(addrReg[ADDR_W-1:COL_W]);
  assign colBus    = MUX_W'(addrReg[COL_W-1:0]);
  assign dramAddr  = ctrl.selCol ? colBus : rowBus;
  assign dramWdata = wdataReg;
  assign respRdata = rdataReg;

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
  import dram_mux_ctrl_pkg::*;
#(
  parameter int ROW_W      = 12,
  parameter int COL_W      = 9,
  parameter int DATA_W     = 8,
  parameter int T_ROWSETUP = 2,
  parameter int T_RCD      = 2,
  parameter int T_CASW     = 2,
  parameter int T_PRE      = 3,
  localparam int ADDR_W    = ROW_W + COL_W,
  localparam int MUX_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              respDone,
  output logic [DATA_W-1:0] respRdata,
  output logic [MUX_W-1:0]  dramAddr,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic [DATA_W-1:0] dramWdata,
  input  logic [DATA_W-1:0] dramRdata
);

  dpCtrl_t ctrl;

  dram_mux_ctrl_fsm #(
    .T_ROWSETUP(T_ROWSETUP), .T_RCD(T_RCD), .T_CASW(T_CASW), .T_PRE(T_PRE)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .ctrl(ctrl), .reqReady(reqReady), .respDone(respDone),
    .rasN(dramRasN), .casN(dramCasN), .weN(dramWeN)
  );

  dram_mux_ctrl_dp #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .MUX_W(MUX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .dramRdata(dramRdata), .dramAddr(dramAddr),
    .dramWdata(dramWdata), .respRdata(respRdata)
  );

endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int MUX_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             respDone,
  input logic             dramRasN,
  input logic             dramCasN,
  input logic             dramWeN,
  input logic [MUX_W-1:0] dramAddr
);

  assert_strobe_nest_R3: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN);

  assert_ras_leads_cas_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> $past(!dramRasN));

  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> $stable(dramAddr));

  assert_col_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> $stable(dramAddr));

  assert_we_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> $stable(dramWeN));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    respDone |=> !respDone);

  assert_done_after_cas_R5: assert property (@(posedge clk) disable iff (!rstN)
    respDone |-> (dramCasN && $past(!dramCasN)));

  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (dramRasN && dramCasN && dramWeN));

endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.MUX_W(MUX_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .respDone(respDone),
  .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
  .dramAddr(dramAddr)
);

// File: tb/dram_mux_ctrl_test.sv
`timescale 1ns/1ps
module dram_mux_ctrl_test;
  localparam int TS = 2, TR = 2, TC = 2, TP = 3;
  localparam int ROW_W = 12, COL_W = 9, DW = 8;
  localparam logic [20:0] NOISE_ADDR = {12'h123, 9'h045};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, reqValid, reqWrite, reqReady, respDone;
  logic [20:0] reqAddr;
  logic [DW-1:0] reqWdata, respRdata, dramWdata, dramRdata;
  logic [11:0] dramAddr;
  logic dramRasN, dramCasN, dramWeN;

  dram_mux_ctrl #(.T_ROWSETUP(TS), .T_RCD(TR), .T_CASW(TC), .T_PRE(TP)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .respDone(respDone), .respRdata(respRdata), .dramAddr(dramAddr),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramWdata(dramWdata), .dramRdata(dramRdata)
  );

  // Behavioural DRAM: strobe-latched row and column, sparse storage
  logic [ROW_W-1:0] mRow = '0;
  logic [COL_W-1:0] mCol = '0;
  logic mWeAtCas = 1'b1;
  logic [DW-1:0] mOut = '0;
  logic [DW-1:0] mem [int];
  int mAccesses = 0;

  always @(negedge dramRasN) mRow = dramAddr[ROW_W-1:0];
  always @(negedge dramCasN) begin
    int key;
    mCol = dramAddr[COL_W-1:0];
    mWeAtCas = dramWeN;
    key = int'({mRow, mCol});
    mAccesses++;
    if (!dramWeN) mem[key] = dramWdata;
    else mOut = mem.exists(key) ? mem[key] : '0;
  end
  assign dramRdata = mOut;

  // Strobe width monitors
  int rasCnt = 0, casCnt = 0, rasW = 0, casW = 0;
  always @(negedge clk) begin
    if (!dramRasN) rasCnt++;
    else if (rasCnt > 0) begin rasW = rasCnt; rasCnt = 0; end
    if (!dramCasN) casCnt++;
    else if (casCnt > 0) begin casW = casCnt; casCnt = 0; end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input logic [20:0] a);
    return DW'(a[20:9] * 7 + a[8:0] * 13 + 1);
  endfunction

  task automatic access(input bit wr, input logic [20:0] a, input logic [DW-1:0] d,
                        input bit noise, output logic [DW-1:0] rd);
    int k, g, acc0;
    bit doneAgain;
    @(negedge clk);
    g = 0;
    while (!reqReady && g < 100) begin @(negedge clk); g++; end
    acc0 = mAccesses;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    k = 1;
    while (!respDone && k < 100) begin
      if (noise && k < 4) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = NOISE_ADDR; reqWdata = 8'hEE;
      end else reqValid = 1'b0;
      @(negedge clk);
      k++;
    end
    reqValid = 1'b0;
    chk("R5 done latency", k, TS + TR + TC + 2);
    rd = respRdata;
    g = 0; doneAgain = 0;
    while (!reqReady && g < 100) begin
      @(negedge clk); g++;
      if (respDone) doneAgain = 1;
    end
    chk("R8 ready gap after done", g, TP);
    chk("R5 done single cycle", int'(doneAgain), 0);
    chk("R2 latched row", int'(mRow), int'(a[20:9]));
    chk("R2 latched column", int'(mCol), int'(a[8:0]));
    chk("R4 RAS low width", rasW, TR + 1 + TC);
    chk("R4 CAS low width", casW, TC);
    chk("R7 write enable at CAS", int'(mWeAtCas), int'(!wr));
    chk("R9 one DRAM access per request", mAccesses - acc0, 1);
  endtask

  logic [11:0] rows [6] = '{12'h000, 12'h001, 12'h555, 12'hAAA, 12'hFFE, 12'hFFF};
  logic [8:0]  cols [6] = '{9'h000, 9'h001, 9'h0AA, 9'h155, 9'h1FE, 9'h1FF};

  initial begin
    logic [DW-1:0] rd;
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 RAS idle in reset", int'(dramRasN), 1);
    chk("R1 CAS idle in reset", int'(dramCasN), 1);
    chk("R1 WE idle in reset", int'(dramWeN), 1);
    chk("R1 ready in reset", int'(reqReady), 1);
    chk("R1 done low in reset", int'(respDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(reqReady), 1);
    chk("R1 RAS idle after reset", int'(dramRasN), 1);

    // Write sweep, then read-back sweep
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++)
        access(1'b1, {rows[r], cols[c]}, pattern({rows[r], cols[c]}), 1'b0, rd);
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++) begin
        access(1'b0, {rows[r], cols[c]}, 8'h00, 1'b0, rd);
        chk("R6 read data", int'(rd), int'(pattern({rows[r], cols[c]})));
      end

    // Requests during a busy access are dropped
    access(1'b1, {12'h555, 9'h0AA}, 8'h3C, 1'b1, rd);
    access(1'b0, NOISE_ADDR, 8'h00, 1'b0, rd);
    chk("R9 busy request left no write", int'(rd), 0);
    access(1'b0, {12'h555, 9'h0AA}, 8'h00, 1'b1, rd);
    chk("R6 R9 overwrite kept in-flight data", int'(rd), 8'h3C);
    access(1'b0, {12'hFFF, 9'h1FF}, 8'h00, 1'b0, rd);
    chk("R6 read top corner", int'(rd), int'(pattern({12'hFFF, 9'h1FF})));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule